// File: doc/BRIEF.md
# Read-Address Command Detector

This block watches the accesses on an 8K x 8 asynchronous SRAM-style bus and picks out a hidden command: six selected read cycles in a row, each at one fixed address. The last address of the six decides the command. One value asks the nonvolatile engine to copy the array into its nonvolatile cells (store). The other asks it to copy them back into the array (recall). Any selected write, or any selected read at an unexpected address, breaks the run.

The bus is sampled in a synchronous clock domain. Each completed access arrives as a one-cycle strobe that carries the address, chip enable, write enable and output enable. All three enables are active low. On the final access of a valid run, the block raises a flag in the same cycle as the strobe, so that the data bus stays in high impedance. In the cycle after that strobe, it pulses either the store request or the recall request for one cycle. While the nonvolatile engine reports busy, the detector holds its start state and issues nothing.

Top module: `addr_seq_cmd_detect`

## Requirements
- R1: The first five steps are selected reads (acc_ce_n=0, acc_we_n=1) at 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0, in that order, on consecutive selected strobes.
- R2: After the five steps, a selected read at 0x0F0F makes store_req high for the cycle after that strobe. A selected read at 0x0F0E does the same for recall_req. The two requests are never high together.
- R3: A selected read at an address that does not match the next step restarts tracking. If that address is 0x0000, it counts as step one of a new run.
- R4: Any selected write strobe (acc_ce_n=0, acc_we_n=0) cancels the run in progress.
- R5: Strobes with acc_ce_n=1 are ignored and neither advance nor reset tracking, whatever their address or write enable. Cycles without a strobe are ignored as well.
- R6: acc_oe_n has no effect on whether a command is recognised.
- R7: dq_hiz is high during the cycle of the sixth strobe of a valid run and low on all other strobes, including the first five steps.
- R8: While nv_busy is high, tracking returns to its start, dq_hiz stays low, and no request is raised in the following cycle.
- R9: After reset, store_req, recall_req and dq_hiz are low and tracking is at its start.
- R10: Each request is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_stb | input | 1 | One-cycle strobe per completed bus access |
| acc_addr | input | 13 | Access address |
| acc_ce_n | input | 1 | Chip enable, active low |
| acc_we_n | input | 1 | Write enable, active low |
| acc_oe_n | input | 1 | Output enable, active low |
| nv_busy | input | 1 | Nonvolatile engine busy |
| store_req | output | 1 | One-cycle store request |
| recall_req | output | 1 | One-cycle recall request |
| dq_hiz | output | 1 | Hold data outputs in high impedance on this access |

## Verification
The assertions check the following on every cycle:
- The two requests are mutually exclusive.
- Each request lasts a single cycle.
- Every request follows a cycle where dq_hiz was high, and every dq_hiz is followed by a request.
- Tracking is restored after a busy cycle, and nothing is requested during busy.

Only the bench scenarios can show the rest:
- The exact address order and the choice between the two final keys.
- The restart rule at 0x0000.
- That writes cancel a run while deselected strobes and output enable do not.

// File: rtl/addr_seq_cmd_detect.sv
module addr_seq_cmd_detect #(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] KEY0 = 'h0000,
  parameter logic [ADDR_W-1:0] KEY1 = 'h1555,
  parameter logic [ADDR_W-1:0] KEY2 = 'h0AAA,
  parameter logic [ADDR_W-1:0] KEY3 = 'h1FFF,
  parameter logic [ADDR_W-1:0] KEY4 = 'h10F0,
  parameter logic [ADDR_W-1:0] STORE_KEY = 'h0F0F,
  parameter logic [ADDR_W-1:0] RECALL_KEY = 'h0F0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_stb,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_ce_n,
  input  logic              acc_we_n,
  input  logic              acc_oe_n,
  input  logic              nv_busy,
  output logic              store_req,
  output logic              recall_req,
  output logic              dq_hiz
);
  localparam int LEAD = 5;
  localparam int STEP_W = $clog2(LEAD + 1);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(LEAD);

  logic [STEP_W-1:0] step_q;
  logic [ADDR_W-1:0] want;
  logic store_q, recall_q;

  always_comb begin
    case (step_q)
      STEP_W'(0): want = KEY0;
      STEP_W'(1): want = KEY1;
      STEP_W'(2): want = KEY2;
      STEP_W'(3): want = KEY3;
      default:    want = KEY4;
    endcase
  end

  wire sel        = acc_stb & ~acc_ce_n & ~nv_busy;
  wire rd         = sel & acc_we_n;
  wire wr         = sel & ~acc_we_n;
  wire at_end     = (step_q == LAST);
  wire hit_store  = rd & at_end & (acc_addr == STORE_KEY);
  wire hit_recall = rd & at_end & (acc_addr == RECALL_KEY);

  assign dq_hiz     = hit_store | hit_recall;
  assign store_req  = store_q;
  assign recall_req = recall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q   <= '0;
      store_q  <= 1'b0;
      recall_q <= 1'b0;
    end else begin
      store_q  <= hit_store;
      recall_q <= hit_recall;
      if (nv_busy || wr) begin
        step_q <= '0;
      end else if (rd) begin
        if (!at_end && acc_addr == want) step_q <= step_q + 1'b1;
        else if (acc_addr == KEY0)        step_q <= STEP_W'(1);
        else                              step_q <= '0;
      end
    end
  end

  p_req_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_req && recall_req));
  p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req || recall_req) |=> !(store_req || recall_req));
  p_hiz_to_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dq_hiz |=> (store_req || recall_req));
  p_req_from_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req || recall_req) |-> $past(dq_hiz));
  p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |=> (!store_req && !recall_req && step_q == '0));
  p_busy_no_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |-> !dq_hiz);
  p_step_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= LAST);
  p_oe_known_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !acc_ce_n) |-> !$isunknown(acc_oe_n));
endmodule

// File: tb/addr_seq_cmd_detect_bench.sv
module addr_seq_cmd_detect_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_stb = 1'b0;
  logic [12:0] acc_addr = '0;
  logic acc_ce_n = 1'b1, acc_we_n = 1'b1, acc_oe_n = 1'b1, nv_busy = 1'b0;
  logic store_req, recall_req, dq_hiz;

  int total = 0, bad = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 0;

  localparam logic [12:0] STORE_A = 13'h0F0F, RECALL_A = 13'h0F0E;

  always #2 clk = ~clk;

  addr_seq_cmd_detect u_addr_seq_cmd_detect (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_addr(acc_addr),
    .acc_ce_n(acc_ce_n), .acc_we_n(acc_we_n), .acc_oe_n(acc_oe_n),
    .nv_busy(nv_busy), .store_req(store_req), .recall_req(recall_req),
    .dq_hiz(dq_hiz));

  function automatic logic [12:0] lead(input int i);
    case (i)
      0: return 13'h0000;
      1: return 13'h1555;
      2: return 13'h0AAA;
      3: return 13'h1FFF;
      default: return 13'h10F0;
    endcase
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  // expected kind: 1 = store, 2 = recall
  task automatic expect_req(input int kind, input string tag);
    exp_q.push_back(kind);
    tag_q.push_back(tag);
  endtask

  task automatic acc(input logic [12:0] a, input bit ce_n, input bit we_n,
                     input bit oe_n, input bit busy, input bit exp_hiz, input string tag);
    @(negedge clk);
    acc_addr = a; acc_ce_n = ce_n; acc_we_n = we_n; acc_oe_n = oe_n;
    nv_busy = busy; acc_stb = 1'b1;
    #1;
    check(dq_hiz == exp_hiz, {tag, " dq_hiz"}, dq_hiz, exp_hiz);
    @(negedge clk);
    acc_stb = 1'b0; nv_busy = 1'b0; acc_ce_n = 1'b1; acc_we_n = 1'b1;
  endtask

  task automatic lead5(input bit oe_n, input string tag);
    for (int i = 0; i < 5; i++) acc(lead(i), 1'b0, 1'b1, oe_n, 1'b0, 1'b0, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the scoreboard whenever a request appears
  always @(negedge clk) begin
    if (rst_n && !done && (store_req || recall_req)) begin
      int got;
      got = store_req ? (recall_req ? 3 : 1) : 2;
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected request", got, 0);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got == e, {t, " request kind"}, got, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(2);
    #1;
    check(!store_req && !recall_req && !dq_hiz, "R9 outputs in reset", {store_req, recall_req, dq_hiz}, 0);
    rst_n = 1'b1;
    idle(2);
    check(!store_req && !recall_req && !dq_hiz, "R9 outputs after reset", {store_req, recall_req, dq_hiz}, 0);

    // R1 R2 R7: plain store
    lead5(1'b0, "R1 store lead");
    expect_req(1, "R2 store");
    acc(STORE_A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R7 store final");
    idle(2);

    // R2: plain recall
    lead5(1'b0, "R1 recall lead");
    expect_req(2, "R2 recall");
    acc(RECALL_A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R7 recall final");
    idle(2);

    // R6: output enable inactive throughout
    lead5(1'b1, "R6 oe high lead");
    expect_req(1, "R6 store oe high");
    acc(STORE_A, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R6 final");
    idle(2);

    // R5: deselected strobes, including writes, interleaved
    acc(lead(0), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 s0");
    acc(13'h0123, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R5 desel read");
    acc(lead(1), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 s1");
    acc(lead(2), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 s2");
    acc(13'h0AAA, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5 desel write");
    idle(3);
    acc(lead(3), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 s3");
    acc(lead(4), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 s4");
    acc(STORE_A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R5 desel final");
    expect_req(2, "R5 recall after deselected");
    acc(RECALL_A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R5 final");
    idle(2);

    // R4: write breaks the run
    acc(lead(0), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 s0");
    acc(lead(1), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 s1");
    acc(lead(2), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 write");
    acc(lead(3), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 s3");
    acc(lead(4), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 s4");
    acc(STORE_A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 no command");
    idle(2);

    // R4: write at the last step
    lead5(1'b0, "R4 lead");
    acc(STORE_A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 write final");
    idle(2);

    // R3: out of order
    acc(lead(0), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 ooo s0");
    acc(lead(2), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 ooo swap");
    acc(lead(1), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 ooo swap");
    acc(lead(3), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 ooo s3");
    acc(lead(4), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 ooo s4");
    acc(RECALL_A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 ooo no command");
    idle(2);

    // R3: restart at 0x0000 counts as step one
    acc(lead(0), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 rs s0");
    acc(lead(1), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 rs s1");
    lead5(1'b0, "R3 restart lead");
    expect_req(2, "R3 recall after restart");
    acc(RECALL_A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R3 restart final");
    idle(2);

    // R3: wrong final key, then back-to-back fresh run
    lead5(1'b0, "R3 badkey lead");
    acc(13'h0F0D, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 bad final key");
    lead5(1'b0, "R3 fresh lead");
    expect_req(1, "R3 store after bad key");
    acc(STORE_A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R3 fresh final");
    // back to back run with no idle gap
    lead5(1'b0, "R2 b2b lead");
    expect_req(2, "R2 back to back recall");
    acc(RECALL_A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R2 b2b final");
    idle(2);

    // R8: busy on the final strobe
    lead5(1'b0, "R8 lead");
    acc(STORE_A, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R8 busy final");
    idle(2);

    // R8: busy pulse mid-run resets tracking
    acc(lead(0), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 m s0");
    acc(lead(1), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 m s1");
    @(negedge clk); nv_busy = 1'b1;
    @(negedge clk); nv_busy = 1'b0;
    acc(lead(2), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 m s2");
    acc(lead(3), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 m s3");
    acc(lead(4), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 m s4");
    acc(STORE_A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 no command after busy");
    idle(2);

    // R8: works again after busy
    lead5(1'b0, "R8 after lead");
    expect_req(1, "R8 store after busy");
    acc(STORE_A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R8 after final");
    idle(4);

    check(exp_q.size() == 0, "R2 missing requests", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule